// File: doc/BRIEF.md
# User-Data Message Reformatting FIFO

This block moves a serial user-data bit stream from a receiving side to a transmitting side that runs at a different bit rate. Both sides share one clock. Each side has its own bit-strobe enable: `in_en` marks an input bit time and `out_en` marks an output bit time. On input, the block picks out 8-bit information units, the short zero gaps between units, and the long zero runs that separate messages. Only unit bits are stored. When the input is idle the store therefore does not fill, and a slower output side can catch up.

On output, a message is released only after the whole message has been received. Between the units of a message the block inserts a zero gap whose length equals the shortest gap between units seen on input. If a unit or a message boundary arrives while the store has no room, the block empties itself at once and can raise a sticky interrupt.

Top module: `udata_refill_fifo`

## Requirements
- R1: Zero bits between units or between messages are never stored. A stream of 96 units, sent as 12 messages of 8 units each with 100-zero separations, passes through the 64-unit store unchanged, with no overflow, when the output runs at half the input bit rate.
- R2: A message is not output until it is complete, which means 9 consecutive zeros have been received after its last unit. Until then the output carries only zeros.
- R3: Between output units the block sends exactly G zeros. G is the shortest input gap between units seen since reset or since the last overflow. The tracker starts at 8 and never increases. G is taken when an output message starts.
- R4: A unit starts at the first 1 bit after zeros and is 8 bits long. Units are output with the first-received bit first, in the order received, with their values unchanged.
- R5: On input, a run of 0 to 8 zeros after a unit is a gap within the message. A run of 9 zeros ends the message. On output, every message is followed by at least 9 zeros, so message lengths are preserved.
- R6: Overflow happens when a unit arrives while 64 units are stored, or when a message ends while 8 complete messages are queued. On overflow, all stored units and queued messages are discarded and the gap tracker returns to 8. Input is then ignored until 9 zeros in a row have been seen.
- R7: `irq` becomes 1 the cycle after an overflow if `irq_en` is 1. It stays at 1 until a cycle with `irq_clr` = 1. An overflow with `irq_en` = 0 leaves `irq` at 0.
- R8: After reset, `out_bit` is 0 and `irq` is 0.
- R9: When no complete message is stored, each output bit time sends 0. This includes the time just after an overflow has flushed the store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_en | input | 1 | Input bit-time strobe |
| in_bit | input | 1 | Input user-data bit, sampled when `in_en` is 1 |
| out_en | input | 1 | Output bit-time strobe |
| out_bit | output | 1 | Output user-data bit, updated at each `out_en` edge |
| irq_en | input | 1 | Allows an overflow to set `irq` |
| irq_clr | input | 1 | Clears `irq` (write one to clear) |
| irq | output | 1 | Sticky overflow interrupt flag |

## Verification
A fault in the input parser or in the gap tracker shows up as a wrong unit value or a wrong gap in the first message output after the fault. That is at most one message time after the message ends on input. A fault in the store or queue counts shows up in one of two ways: as a message released before its end (ones appearing while the input is still inside the message), or as units lost or repeated in the replayed stream. A missed or false overflow shows up on `irq` one cycle after the offending unit or message end. It also shows up as stale units that still appear, or units that go missing, after output is enabled.

// File: rtl/udr_pkg.sv
package udr_pkg;
    typedef enum logic [1:0] {P_IDLE, P_UNIT, P_GAP, P_SKIP} parse_st_t;
    typedef enum logic [1:0] {R_IDLE, R_UNIT, R_GAP} replay_st_t;
endpackage

// File: rtl/udr_parse.sv
module udr_parse
    import udr_pkg::*;
#(
    parameter int UNIT_W  = 8,
    parameter int CNT_W   = 7,
    parameter int GAP_W   = 4,
    parameter int SEP_LEN = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              bit_en,
    input  logic              bit_in,
    output logic              unit_vld,
    output logic [UNIT_W-1:0] unit_data,
    output logic              msg_done,
    output logic [CNT_W-1:0]  msg_len,
    output logic [GAP_W-1:0]  min_gap
);
    typedef struct packed {
        parse_st_t         st;
        logic [UNIT_W-1:0] sh;
        logic [GAP_W-1:0]  k;
        logic [CNT_W-1:0]  units;
        logic [GAP_W-1:0]  minq;
        logic              uv;
        logic              md;
    } pstate_t;

    localparam pstate_t RST = '{st: P_IDLE, sh: '0, k: '0, units: '0,
                                minq: GAP_W'(UNIT_W), uv: 1'b0, md: 1'b0};

    pstate_t q, d;

    always_comb begin
        d    = q;
        d.uv = 1'b0;
        d.md = 1'b0;
        if (bit_en) begin
            case (q.st)
                P_IDLE: if (bit_in) begin
                    d.st    = P_UNIT;
                    d.sh    = UNIT_W'(1);
                    d.k     = GAP_W'(1);
                    d.units = '0;
                end
                P_UNIT: begin
                    d.sh = (q.sh << 1) | UNIT_W'(bit_in);
                    d.k  = q.k + 1'b1;
                    if (q.k == GAP_W'(UNIT_W - 1)) begin
                        d.uv    = 1'b1;
                        d.units = q.units + 1'b1;
                        d.st    = P_GAP;
                        d.k     = '0;
                    end
                end
                P_GAP: if (bit_in) begin
                    if (q.k < q.minq) d.minq = q.k;
                    d.st = P_UNIT;
                    d.sh = UNIT_W'(1);
                    d.k  = GAP_W'(1);
                end else if (q.k == GAP_W'(SEP_LEN - 1)) begin
                    d.md = 1'b1;
                    d.st = P_IDLE;
                    d.k  = '0;
                end else begin
                    d.k = q.k + 1'b1;
                end
                default: if (bit_in) begin
                    d.k = '0;
                end else if (q.k == GAP_W'(SEP_LEN - 1)) begin
                    d.st = P_IDLE;
                    d.k  = '0;
                end else begin
                    d.k = q.k + 1'b1;
                end
            endcase
        end
        if (flush) begin
            d.uv    = 1'b0;
            d.md    = 1'b0;
            d.units = '0;
            d.minq  = GAP_W'(UNIT_W);
            if (d.st != P_IDLE) begin
                d.st = P_SKIP;
                d.k  = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= RST;
        else        q <= d;
    end

    assign unit_vld  = q.uv;
    assign unit_data = q.sh;
    assign msg_done  = q.md;
    assign msg_len   = q.units;
    assign min_gap   = q.minq;

    assert_min_gap_monotone_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !flush |=> (q.minq <= $past(q.minq)));
    assert_min_gap_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        q.minq <= GAP_W'(UNIT_W));
endmodule

// File: rtl/udr_store.sv
module udr_store #(
    parameter int UNIT_W     = 8,
    parameter int DEPTH      = 64,
    parameter int MSGQ_DEPTH = 8,
    parameter int CNT_W      = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_vld,
    input  logic [UNIT_W-1:0] wr_data,
    input  logic              msg_push,
    input  logic [CNT_W-1:0]  msg_len_in,
    input  logic              unit_pop,
    input  logic              msg_pop,
    output logic [UNIT_W-1:0] rd_data,
    output logic              msg_avail,
    output logic [CNT_W-1:0]  msg_len_out,
    output logic              ovf
);
    localparam int AW = $clog2(DEPTH);
    localparam int MW = $clog2(MSGQ_DEPTH);

    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [AW:0]   ucnt;
        logic [MW-1:0] mwp;
        logic [MW-1:0] mrp;
        logic [MW:0]   mcnt;
    } sstate_t;

    sstate_t q, d;
    logic [UNIT_W-1:0] mem [DEPTH];
    logic [CNT_W-1:0]  mq  [MSGQ_DEPTH];

    assign ovf = (wr_vld && q.ucnt == (AW+1)'(DEPTH)) ||
                 (msg_push && q.mcnt == (MW+1)'(MSGQ_DEPTH));

    always_comb begin
        d = q;
        if (ovf) begin
            d = '0;
        end else begin
            if (wr_vld)   d.wp  = q.wp + 1'b1;
            if (unit_pop) d.rp  = q.rp + 1'b1;
            d.ucnt = q.ucnt + (AW+1)'(wr_vld) - (AW+1)'(unit_pop);
            if (msg_push) d.mwp = q.mwp + 1'b1;
            if (msg_pop)  d.mrp = q.mrp + 1'b1;
            d.mcnt = q.mcnt + (MW+1)'(msg_push) - (MW+1)'(msg_pop);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_ff @(posedge clk) begin
        if (wr_vld && !ovf)   mem[q.wp] <= wr_data;
        if (msg_push && !ovf) mq[q.mwp] <= msg_len_in;
    end

    assign rd_data     = mem[q.rp];
    assign msg_len_out = mq[q.mrp];
    assign msg_avail   = (q.mcnt != '0);

    assert_unit_pop_has_data_R2: assert property (@(posedge clk) disable iff (!rst_n)
        unit_pop |-> (q.ucnt != '0));
    assert_msg_pop_has_entry_R2: assert property (@(posedge clk) disable iff (!rst_n)
        msg_pop |-> (q.mcnt != '0));
    assert_flush_empties_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> (q.ucnt == '0 && q.mcnt == '0));
endmodule

// File: rtl/udr_replay.sv
module udr_replay
    import udr_pkg::*;
#(
    parameter int UNIT_W  = 8,
    parameter int CNT_W   = 7,
    parameter int GAP_W   = 4,
    parameter int SEP_LEN = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              bit_en,
    input  logic              msg_avail,
    input  logic [CNT_W-1:0]  msg_len,
    input  logic [UNIT_W-1:0] unit_in,
    input  logic [GAP_W-1:0]  gap_len,
    output logic              unit_pop,
    output logic              msg_pop,
    output logic              bit_out
);
    typedef struct packed {
        replay_st_t        st;
        logic [UNIT_W-1:0] sh;
        logic [GAP_W-1:0]  k;
        logic [CNT_W-1:0]  left;
        logic [GAP_W-1:0]  gap;
        logic [GAP_W-1:0]  sep;
        logic              ob;
    } rstate_t;

    localparam rstate_t RST = '{st: R_IDLE, sh: '0, k: '0, left: '0, gap: '0,
                                sep: GAP_W'(SEP_LEN), ob: 1'b0};

    rstate_t q, d;

    always_comb begin
        d        = q;
        unit_pop = 1'b0;
        msg_pop  = 1'b0;
        if (bit_en) begin
            case (q.st)
                R_IDLE: if (msg_avail && q.sep == GAP_W'(SEP_LEN)) begin
                    d.ob     = unit_in[UNIT_W-1];
                    d.sh     = unit_in << 1;
                    d.k      = GAP_W'(1);
                    d.left   = msg_len;
                    d.gap    = gap_len;
                    d.st     = R_UNIT;
                    unit_pop = 1'b1;
                end else begin
                    d.ob = 1'b0;
                    if (q.sep != GAP_W'(SEP_LEN)) d.sep = q.sep + 1'b1;
                end
                R_UNIT: begin
                    d.ob = q.sh[UNIT_W-1];
                    d.sh = q.sh << 1;
                    d.k  = q.k + 1'b1;
                    if (q.k == GAP_W'(UNIT_W - 1)) begin
                        d.k = '0;
                        if (q.left == CNT_W'(1)) begin
                            msg_pop = 1'b1;
                            d.st    = R_IDLE;
                            d.sep   = '0;
                        end else begin
                            d.left = q.left - 1'b1;
                            d.st   = R_GAP;
                        end
                    end
                end
                default: if (q.k == q.gap) begin
                    d.ob     = unit_in[UNIT_W-1];
                    d.sh     = unit_in << 1;
                    d.k      = GAP_W'(1);
                    d.st     = R_UNIT;
                    unit_pop = 1'b1;
                end else begin
                    d.ob = 1'b0;
                    d.k  = q.k + 1'b1;
                end
            endcase
        end
        if (flush) begin
            d.st  = R_IDLE;
            d.sep = '0;
            d.k   = '0;
            d.ob  = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= RST;
        else        q <= d;
    end

    assign bit_out = q.ob;

    assert_idle_sends_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == R_IDLE && bit_en && !msg_avail) |=> !bit_out);
endmodule

// File: rtl/udata_refill_fifo.sv
module udata_refill_fifo #(
    parameter int UNIT_W     = 8,
    parameter int DEPTH      = 64,
    parameter int MSGQ_DEPTH = 8,
    parameter int SEP_LEN    = 9
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_en,
    input  logic in_bit,
    input  logic out_en,
    output logic out_bit,
    input  logic irq_en,
    input  logic irq_clr,
    output logic irq
);
    localparam int CNT_W = $clog2(DEPTH) + 1;
    localparam int GAP_W = $clog2(((SEP_LEN > UNIT_W) ? SEP_LEN : UNIT_W) + 1);

    logic              flush;
    logic              unit_vld, msg_done, unit_pop, msg_pop, msg_avail;
    logic [UNIT_W-1:0] unit_wr, unit_rd;
    logic [CNT_W-1:0]  len_wr, len_rd;
    logic [GAP_W-1:0]  min_gap;
    logic              irq_d, irq_q;

    udr_parse #(.UNIT_W(UNIT_W), .CNT_W(CNT_W), .GAP_W(GAP_W), .SEP_LEN(SEP_LEN)) u_parse (
        .clk(clk), .rst_n(rst_n), .flush(flush), .bit_en(in_en), .bit_in(in_bit),
        .unit_vld(unit_vld), .unit_data(unit_wr), .msg_done(msg_done),
        .msg_len(len_wr), .min_gap(min_gap));

    udr_store #(.UNIT_W(UNIT_W), .DEPTH(DEPTH), .MSGQ_DEPTH(MSGQ_DEPTH), .CNT_W(CNT_W)) u_store (
        .clk(clk), .rst_n(rst_n), .wr_vld(unit_vld), .wr_data(unit_wr),
        .msg_push(msg_done), .msg_len_in(len_wr), .unit_pop(unit_pop), .msg_pop(msg_pop),
        .rd_data(unit_rd), .msg_avail(msg_avail), .msg_len_out(len_rd), .ovf(flush));

    udr_replay #(.UNIT_W(UNIT_W), .CNT_W(CNT_W), .GAP_W(GAP_W), .SEP_LEN(SEP_LEN)) u_replay (
        .clk(clk), .rst_n(rst_n), .flush(flush), .bit_en(out_en), .msg_avail(msg_avail),
        .msg_len(len_rd), .unit_in(unit_rd), .gap_len(min_gap),
        .unit_pop(unit_pop), .msg_pop(msg_pop), .bit_out(out_bit));

    always_comb begin
        irq_d = (flush && irq_en) || (irq_q && !irq_clr);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= irq_d;
    end

    assign irq = irq_q;

    assert_irq_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !irq_clr) |=> irq);
    assert_irq_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(flush && irq_en));
endmodule

// File: tb/sim_udata_refill_fifo.sv
module sim_udata_refill_fifo;
    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic rst_n = 1'b0, in_en = 1'b0, in_bit = 1'b0, out_en = 1'b0;
    logic irq_en = 1'b0, irq_clr = 1'b0;
    logic out_bit, irq;

    udata_refill_fifo u0 (.clk(clk), .rst_n(rst_n), .in_en(in_en), .in_bit(in_bit),
        .out_en(out_en), .out_bit(out_bit), .irq_en(irq_en), .irq_clr(irq_clr), .irq(irq));

    int checks = 0, errors = 0;
    bit done = 0;

    logic obits [0:32767];
    int ocnt = 0, out_div = 0, odc = 0;

    int eu [0:1023];
    int elen [0:63];
    int egap [0:63];
    int eun = 0, em = 0, run_min = 8, seed = 1;

    always @(negedge clk) begin
        if (out_en) begin
            if (ocnt < 32768) obits[ocnt] = out_bit;
            ocnt++;
        end
        if (out_div == 0) begin
            out_en = 1'b0;
            odc = 0;
        end else begin
            odc++;
            if (odc >= out_div) begin
                odc = 0;
                out_en = 1'b1;
            end else begin
                out_en = 1'b0;
            end
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic send_bit(input logic b);
        @(negedge clk);
        in_en = 1'b1;
        in_bit = b;
        @(negedge clk);
        in_en = 1'b0;
        in_bit = 1'b0;
    endtask

    task automatic send_zeros(input int n);
        for (int i = 0; i < n; i++) send_bit(1'b0);
    endtask

    task automatic send_unit(input logic [7:0] u);
        for (int j = 7; j >= 0; j--) send_bit(u[j]);
    endtask

    task automatic send_msg(input int n, input int ga, input int gb, input int pad, input bit model);
        for (int i = 0; i < n; i++) begin
            logic [7:0] u;
            u = 8'h80 | 8'((seed * 37 + i * 53) & 127);
            if (model) begin
                eu[eun] = int'(u);
                eun++;
            end
            send_unit(u);
            if (i < n - 1) begin
                int g;
                g = (i % 2 == 1) ? gb : ga;
                send_zeros(g);
                if (model && g < run_min) run_min = g;
            end
        end
        seed++;
        if (model) begin
            elen[em] = n;
            egap[em] = run_min;
            em++;
        end
        send_zeros(pad);
    endtask

    task automatic start_scenario();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        eun = 0;
        em = 0;
        run_min = 8;
        ocnt = 0;
    endtask

    function automatic int count_ones();
        int c = 0;
        for (int i = 0; i < ocnt && i < 32768; i++) if (obits[i]) c++;
        return c;
    endfunction

    task automatic analyze();
        int p = 0, m = 0, ui = 0;
        while (p < ocnt) begin
            if (!obits[p]) begin
                p++;
                continue;
            end
            begin
                int units = 0;
                bit fin = 0;
                while (!fin) begin
                    int v = 0, z = 0;
                    if (p + 8 > ocnt) begin
                        check(0, "R4 truncated unit", p, ocnt);
                        p = ocnt;
                        break;
                    end
                    for (int j = 0; j < 8; j++) v = (v << 1) | int'(obits[p + j]);
                    p += 8;
                    check(ui < eun && v == eu[ui], "R4 unit value", v, (ui < eun) ? eu[ui] : -1);
                    ui++;
                    units++;
                    while (p < ocnt && !obits[p] && z < 9) begin
                        z++;
                        p++;
                    end
                    if (z <= 8 && p < ocnt && obits[p]) begin
                        check(m < em && z == egap[m], "R3 output gap", z, (m < em) ? egap[m] : -1);
                    end else begin
                        check(m < em && units == elen[m], "R5 message length", units,
                              (m < em) ? elen[m] : -1);
                        fin = 1;
                    end
                end
                m++;
            end
        end
        check(m == em, "R5 message count", m, em);
        check(ui == eun, "R4 unit count", ui, eun);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=1 expected=0");
        finish_run();
    end

    initial begin
        // R8: reset state
        start_scenario();
        check(out_bit == 1'b0, "R8 out_bit after reset", int'(out_bit), 0);
        check(irq == 1'b0, "R8 irq after reset", int'(irq), 0);

        // R3 R4 R5: sweep every legal in-message gap at two output rates
        for (int od = 1; od <= 3; od += 2) begin
            for (int g = 0; g <= 8; g++) begin
                start_scenario();
                out_div = od;
                send_msg(3, g, g, 12, 1);
                repeat (400) @(negedge clk);
                analyze();
            end
        end

        // R3: shortest gap wins, and a later wider gap does not raise it
        start_scenario();
        out_div = 1;
        send_msg(4, 6, 2, 12, 1);
        send_msg(4, 5, 5, 12, 1);
        repeat (400) @(negedge clk);
        check(egap[1] == 2, "R3 tracker kept minimum", egap[1], 2);
        analyze();

        // R2: nothing leaves while the message is still open
        start_scenario();
        out_div = 1;
        send_msg(3, 1, 1, 8, 1);
        repeat (60) @(negedge clk);
        check(count_ones() == 0, "R2 output before message end", count_ones(), 0);
        send_zeros(1);
        repeat (300) @(negedge clk);
        analyze();

        // R1: 96 units through a 64-unit store with slow output
        start_scenario();
        irq_en = 1'b1;
        out_div = 4;
        for (int i = 0; i < 12; i++) send_msg(8, 1, 1, 100, 1);
        repeat (3000) @(negedge clk);
        check(irq == 1'b0, "R1 no overflow with padding", int'(irq), 0);
        analyze();

        // R6 R7: unit overflow with interrupt enabled
        start_scenario();
        irq_en = 1'b1;
        out_div = 0;
        send_msg(65, 0, 0, 12, 0);
        check(irq == 1'b1, "R7 irq on unit overflow", int'(irq), 1);
        repeat (20) @(negedge clk);
        check(irq == 1'b1, "R7 irq sticky", int'(irq), 1);
        @(negedge clk);
        irq_clr = 1'b1;
        @(negedge clk);
        irq_clr = 1'b0;
        check(irq == 1'b0, "R7 irq cleared", int'(irq), 0);
        ocnt = 0;
        out_div = 1;
        repeat (200) @(negedge clk);
        check(ocnt > 100, "R9 output strobes ran", ocnt, 101);
        check(count_ones() == 0, "R6 R9 flushed store sends zeros", count_ones(), 0);
        send_msg(3, 4, 4, 12, 1);
        repeat (300) @(negedge clk);
        check(egap[0] == 4, "R6 tracker reset to 8 then 4", egap[0], 4);
        analyze();

        // R6 R7: message-queue overflow with interrupt disabled
        start_scenario();
        irq_en = 1'b0;
        out_div = 0;
        for (int i = 0; i < 9; i++) send_msg(1, 0, 0, 10, 0);
        repeat (10) @(negedge clk);
        check(irq == 1'b0, "R7 no irq when disabled", int'(irq), 0);
        ocnt = 0;
        out_div = 1;
        repeat (200) @(negedge clk);
        check(count_ones() == 0, "R6 queued messages discarded", count_ones(), 0);
        send_msg(2, 3, 3, 12, 1);
        repeat (300) @(negedge clk);
        analyze();

        finish_run();
    end
endmodule